// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block models a single-port synchronous SRAM with a built-in four-word burst sequencer. Each word is four 9-bit byte lanes. The block samples address, data, selects and controls on the rising clock edge. Two start strobes open an access. One starts an access only while the device is selected. The other always starts one, and when the device is not selected it closes the open access instead. A step input then walks a 2-bit counter through the remaining words of the four-word group. The group's upper address bits stay fixed.

Two static mode inputs shape the access. One chooses linear or interleaved burst order. The other chooses a one-cycle (flow-through) or two-cycle (pipelined) read path. The output enable and the sleep input act on the read port without waiting for a clock. While asleep, the block ignores all traffic and keeps its memory contents.

Top module: `burst_sram`

## Requirements
- R1: An access opens at a rising edge when `force_start` is high, or when `sel_start` is high while selected (`en_a_n`=0, `en_b`=1, `en_c_n`=0). The address on `addr` is loaded at that edge. In flow-through mode, read data for it is on `rdata` with `rdata_en`=1 after that same edge.
- R2: `sel_start` sampled while deselected is ignored. The open access continues at its current address. `force_start` sampled while deselected closes the access. `rdata_en` is 0 after that edge in flow-through mode, and one edge later in pipelined mode. `step` has no effect while no access is open.
- R3: With `lin_order`=0 (interleaved), each `step` edge with no start strobe advances the counter from 0 to 3. The low two address bits then equal the start's low two bits XOR the count.
- R4: With `lin_order`=1 (linear), the low two bits equal the start's low two bits plus the count, modulo 4. In both orders the bits above bit 1 stay those of the start address.
- R5: An edge in an open access with no start strobe and `step`=0 keeps the same address, and reading continues from that word.
- R6: `all_we`=1 writes every lane of the current word, whatever `lane_wr_en` and `lane_we` are.
- R7: With `all_we`=0, a write happens only if `lane_wr_en`=1. It then touches only lane i (`wdata` bits 9i+8..9i) where `lane_we[i]`=1. A cycle with no write enabled is a read.
- R8: An access opened by `sel_start` while selected is a read, and the write controls are ignored at that edge. Writes happen at edges opened by `force_start` or at continuing edges. A write edge gives `rdata_en`=0 after it.
- R9: With `pipe_mode`=0, data appears after the edge that presents the address (a four-word burst is 2-1-1-1 cycles). With `pipe_mode`=1, it appears one edge later (3-1-1-1).
- R10: `oe_n`=1 forces `rdata_en`=0 and `rdata`=0 at once, with no clock edge needed.
- R11: While `sleep`=1, `rdata_en` is 0 at once and edges change nothing. After `sleep` falls, the block resumes the access that was open, and the stored words are unchanged.
- R12: After reset, `rdata_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address, loaded on a start |
| wdata | input | 36 | Write data, four 9-bit lanes |
| en_a_n | input | 1 | Select, active low |
| en_b | input | 1 | Select, active high |
| en_c_n | input | 1 | Select, active low |
| sel_start | input | 1 | Start strobe honoured only when selected |
| force_start | input | 1 | Start strobe always honoured; deselects when unselected |
| step | input | 1 | Advance the burst counter |
| lane_we | input | 4 | Per-lane write strobes |
| lane_wr_en | input | 1 | Enables per-lane writes |
| all_we | input | 1 | Writes all lanes |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through |
| lin_order | input | 1 | 1 = linear burst, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdata | output | 36 | Read data, zero when not driven |
| rdata_en | output | 1 | Read data valid and driven |

## Verification
A four-word burst is written using interleaved stepping, then read back from a different starting word. The read-back order only matches if the XOR sequence is right. A pipelined linear burst from an odd start then separates the two orders, and it also checks the extra cycle of latency. Several write patterns are tried at single addresses: all lanes, alternate lanes only, a global write with no lane strobes, and strobes with the enable off. Each of these leaves a word whose value shows which lanes were written. Deselect, suspend, sleep and output-enable cases run as sequences where a wrong address load, or a missing one, would return a different stored word.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW = 6,
  parameter int LANES = 4,
  parameter int LW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic                en_a_n,
  input  logic                en_b,
  input  logic                en_c_n,
  input  logic                sel_start,
  input  logic                force_start,
  input  logic                step,
  input  logic [LANES-1:0]    lane_we,
  input  logic                lane_wr_en,
  input  logic                all_we,
  input  logic                pipe_mode,
  input  logic                lin_order,
  input  logic                oe_n,
  input  logic                sleep,
  output logic [LANES*LW-1:0] rdata,
  output logic                rdata_en
);
  localparam int DW = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] a_reg, base, eff_addr;
  logic [1:0]    cnt;
  logic          sess, rd_act, p_valid;
  logic [DW-1:0] p_data;
  logic [LANES-1:0] wr_lanes;

  function automatic logic [1:0] burst_lo(input logic [1:0] b, input logic [1:0] c, input logic lin);
    return lin ? b + c : b ^ c;
  endfunction

  wire selected = !en_a_n && en_b && !en_c_n;
  wire start    = force_start || (sel_start && selected);
  wire go       = start && selected;
  wire cont     = !start && sess;
  wire eff_act  = go || cont;
  wire adv_now  = cont && step;
  wire [1:0] nxt_cnt = cnt + 2'd1;
  wire wr_allow = eff_act && !(sel_start && selected);
  wire do_wr    = wr_allow && |wr_lanes;

  assign wr_lanes = all_we ? {LANES{1'b1}} : (lane_wr_en ? lane_we : '0);

  always_comb begin
    if (go)           eff_addr = addr;
    else if (adv_now) eff_addr = {base[AW-1:2], burst_lo(base[1:0], nxt_cnt, lin_order)};
    else              eff_addr = a_reg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_reg   <= '0;
      base    <= '0;
      cnt     <= '0;
      sess    <= 1'b0;
      rd_act  <= 1'b0;
      p_valid <= 1'b0;
      p_data  <= '0;
    end else if (!sleep) begin
      a_reg   <= eff_addr;
      rd_act  <= eff_act && !do_wr;
      p_valid <= rd_act;
      p_data  <= mem[a_reg];
      if (go) begin
        base <= addr;
        cnt  <= '0;
        sess <= 1'b1;
      end else if (start) begin
        sess <= 1'b0;
      end else if (adv_now) begin
        cnt <= nxt_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !sleep && do_wr) begin
      for (int l = 0; l < LANES; l++)
        if (wr_lanes[l]) mem[eff_addr][l*LW +: LW] <= wdata[l*LW +: LW];
    end
  end

  wire           out_valid = pipe_mode ? p_valid : rd_act;
  wire [DW-1:0]  out_data  = pipe_mode ? p_data : mem[a_reg];

  assign rdata_en = out_valid && !oe_n && !sleep;
  assign rdata    = rdata_en ? out_data : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_a_n,
  input logic          en_b,
  input logic          en_c_n,
  input logic          sel_start,
  input logic          force_start,
  input logic          step,
  input logic          pipe_mode,
  input logic          oe_n,
  input logic          sleep,
  input logic [DW-1:0] rdata,
  input logic          rdata_en,
  input logic [AW-1:0] a_reg,
  input logic          rd_act,
  input logic          p_valid
);
  wire sel = !en_a_n && en_b && !en_c_n;

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !rdata_en);

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) sleep |=> a_reg == $past(a_reg));

  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> (!rdata_en && rdata == '0));

  // R2
  desel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_start && !force_start && !sel && !step && !sleep) |=> a_reg == $past(a_reg));

  // R2
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_start && !sel && !sleep && !pipe_mode) |=> (!rdata_en || pipe_mode));

  // R4
  burst_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sel_start && !force_start && !sleep) |=> a_reg[AW-1:2] == $past(a_reg[AW-1:2]));

  // R9
  pipe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n) !sleep |=> p_valid == $past(rd_act));
endmodule

bind burst_sram burst_sram_chk #(.AW(AW), .DW(LANES*LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
  .sel_start(sel_start), .force_start(force_start), .step(step),
  .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep(sleep), .rdata(rdata),
  .rdata_en(rdata_en), .a_reg(a_reg), .rd_act(rd_act), .p_valid(p_valid)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/100ps
module sim_burst_sram;
  localparam real HALF = 2.5;
  localparam logic [35:0] D8  = 36'h100200308;
  localparam logic [35:0] D9  = 36'h400500609;
  localparam logic [35:0] D10 = 36'h70080090A;
  localparam logic [35:0] D11 = 36'hA00B00C0B;
  localparam logic [35:0] D9B = 36'h407FC07FF;
  localparam logic [35:0] DG  = 36'h123456789;

  logic clk = 0, rst_n = 0;
  logic [5:0] addr = '0;
  logic [35:0] wdata = '0;
  logic en_a_n = 0, en_b = 1, en_c_n = 0;
  logic sel_start = 0, force_start = 0, step = 0;
  logic [3:0] lane_we = '0;
  logic lane_wr_en = 0, all_we = 0;
  logic pipe_mode = 0, lin_order = 0, oe_n = 0, sleep = 0;
  logic [35:0] rdata;
  logic rdata_en;
  int checks = 0, fails = 0;
  bit done = 0;

  burst_sram u0 (.*);

  always #(HALF) clk = ~clk;

  typedef struct packed {
    logic s, sp, fs, st, gw, bw;
    logic [3:0] be;
    logic [5:0] a;
    logic [35:0] wd;
    logic een;
    logic [35:0] ed;
    logic [3:0] req;
  } vec_t;

  localparam vec_t TBL [18] = '{
    '{1,0,1,0,1,0,4'h0,6'd8, D8, 0,36'h0,4'd6},   // R6 write start
    '{1,0,0,1,1,0,4'h0,6'd0, D9, 0,36'h0,4'd3},   // R3 burst write
    '{1,0,0,1,1,0,4'h0,6'd0, D10,0,36'h0,4'd3},
    '{1,0,0,1,1,0,4'h0,6'd0, D11,0,36'h0,4'd3},
    '{1,1,0,0,0,0,4'h0,6'd10,36'h0,1,D10,4'd1},   // R1
    '{1,0,0,1,0,0,4'h0,6'd0, 36'h0,1,D11,4'd3},   // R3 10^1
    '{1,0,0,1,0,0,4'h0,6'd0, 36'h0,1,D8, 4'd3},   // R3 10^2
    '{1,0,0,1,0,0,4'h0,6'd0, 36'h0,1,D9, 4'd3},   // R3 10^3
    '{1,0,1,0,0,1,4'h5,6'd9, 36'hFFFFFFFFF,0,36'h0,4'd7}, // R7 lanes 0,2
    '{1,1,0,0,0,0,4'h0,6'd9, 36'h0,1,D9B,4'd7},
    '{1,0,1,0,0,0,4'hF,6'd8, 36'h0,1,D8, 4'd7},   // R7 enable off -> read
    '{1,0,1,0,1,0,4'h0,6'd10,DG, 0,36'h0,4'd6},   // R6 no strobes
    '{1,1,0,0,1,0,4'h0,6'd10,36'hFFFFFFFFF,1,DG,4'd8}, // R8
    '{0,1,0,0,0,0,4'h0,6'd8, 36'h0,1,DG, 4'd2},   // R2 ignored
    '{0,0,1,0,0,0,4'h0,6'd8, 36'h0,0,36'h0,4'd2}, // R2 deselect
    '{1,0,0,1,0,0,4'h0,6'd0, 36'h0,0,36'h0,4'd2}, // R2 step idle
    '{1,1,0,0,0,0,4'h0,6'd11,36'h0,1,D11,4'd1},
    '{1,0,0,0,0,0,4'h0,6'd0, 36'h0,1,D11,4'd5}    // R5 suspend
  };

  task automatic step_cyc(input logic s, input logic sp, input logic fs, input logic st,
                          input logic gw, input logic bw, input logic [3:0] be,
                          input logic [5:0] a, input logic [35:0] wd);
    en_a_n = !s; en_b = s; en_c_n = !s;
    sel_start = sp; force_start = fs; step = st;
    all_we = gw; lane_wr_en = bw; lane_we = be; addr = a; wdata = wd;
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic een, input logic [35:0] ed, input string tag);
    checks++;
    if (rdata_en !== een || rdata !== ed) begin
      fails++;
      $display("FAIL %s: en=%0b data=%h, expected en=%0b data=%h", tag, rdata_en, rdata, een, ed);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(0, 36'h0, "R12 reset");

    foreach (TBL[i]) begin
      step_cyc(TBL[i].s, TBL[i].sp, TBL[i].fs, TBL[i].st, TBL[i].gw, TBL[i].bw,
               TBL[i].be, TBL[i].a, TBL[i].wd);
      chk(TBL[i].een, TBL[i].ed, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // R9 pipelined linear burst from 9 (R4 order 9,10,11,8)
    step_cyc(0,0,1,0,0,0,4'h0,6'd0,36'h0);
    pipe_mode = 1; lin_order = 1;
    step_cyc(1,1,0,0,0,0,4'h0,6'd9,36'h0); chk(0, 36'h0, "R9 first edge");
    step_cyc(1,0,0,1,0,0,4'h0,6'd0,36'h0); chk(1, D9B, "R9 word0");
    step_cyc(1,0,0,1,0,0,4'h0,6'd0,36'h0); chk(1, DG,  "R4 word1");
    step_cyc(1,0,0,1,0,0,4'h0,6'd0,36'h0); chk(1, D11, "R4 word2");
    step_cyc(1,0,0,0,0,0,4'h0,6'd0,36'h0); chk(1, D8,  "R4 word3 wrap");
    step_cyc(0,0,1,0,0,0,4'h0,6'd0,36'h0); chk(1, D8,  "R2 pipe deselect lag");
    step_cyc(1,0,0,0,0,0,4'h0,6'd0,36'h0); chk(0, 36'h0, "R2 pipe idle");

    // R11 sleep
    pipe_mode = 0; lin_order = 0;
    step_cyc(1,1,0,0,0,0,4'h0,6'd11,36'h0); chk(1, D11, "R11 before sleep");
    sleep = 1; #1; chk(0, 36'h0, "R11 async off");
    step_cyc(1,0,1,0,1,0,4'h0,6'd8,36'h0); chk(0, 36'h0, "R11 asleep");
    sleep = 0; #1; chk(1, D11, "R11 access not taken");
    step_cyc(1,1,0,0,0,0,4'h0,6'd8,36'h0); chk(1, D8, "R11 contents kept");

    // R10 output enable
    oe_n = 1;
    step_cyc(1,1,0,0,0,0,4'h0,6'd10,36'h0); chk(0, 36'h0, "R10 oe high");
    oe_n = 0; #1; chk(1, DG, "R10 oe async on");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(HALF * 2 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: en=%0b data=%h, expected completion", rdata_en, rdata);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule